// File: doc/BRIEF.md
# Configurable Synchronous Serial Channel

This block is one byte-wide synchronous serial transceiver. It moves a byte between an internal buffer register and a serial data line, one bit per serial clock pulse, most significant bit first. As clock master it makes the serial clock itself, changing the clock level once per baud tick supplied from outside. As clock slave it follows a clock that arrives on the clock pin. In slave mode that clock, and the incoming data in both modes, pass through a synchronizer into the system clock domain.

Software loads or reads the buffer and sets the enable and direction bits. A transfer starts on its own once the channel is enabled and the buffer is in the right state. When the byte is complete, the channel updates the buffer status, pulses an interrupt request, and then takes one of three configured follow-up actions. It can arm itself to transmit, arm itself to receive, or switch itself off. Because of this, a received byte can be echoed back, or a transmission can be followed straight away by a reception, with no software step in between.

The clock rest level, the edge that launches transmit bits and the edge that captures receive bits are three separate settings. They must be held steady while a transfer is in progress.

Top module: `sync_serial_chan`

## Requirements
- R1: A transfer starts only while `chan_en` is 1 and the buffer state fits the direction: `buf_full`=1 when `chan_tx`=1, `buf_full`=0 when `chan_tx`=0. Otherwise the serial clock stays at its rest level and `chan_busy` stays 0.
- R2: Every transfer has exactly eight serial clock pulses and carries the byte MSB first. In master mode each `baud_tick` during a transfer moves the clock by exactly one edge, and the clock does not move without a tick.
- R3: `cfg_tx_rise`=1 launches transmit bits on rising clock edges and 0 launches them on falling edges. `cfg_rx_rise`=1 captures receive bits on rising edges and 0 captures them on falling edges. `sd_out` changes only on a launch edge.
- R4: `cfg_idle_hi` sets the clock rest level (1 = high). In master mode `sclk_out` sits at that level between transfers and returns to it after the eighth pulse.
- R5: With `cfg_master`=0 the channel takes its clock from `sclk_in` and keeps `sclk_oe` at 0. With `cfg_master`=1, `sclk_oe` is 1.
- R6: At the end of a byte, a transmission clears `buf_full`. A reception puts the received byte in `buf_rdata` and sets `buf_full`. In both cases `irq` is high for exactly one cycle.
- R7: At the end of a byte, `cfg_next` decides what follows: 2'b01 sets `chan_en`=1 and `chan_tx`=1, 2'b10 sets `chan_en`=1 and `chan_tx`=0, and 2'b00 or 2'b11 sets `chan_en`=0. If the new state meets R1, the next transfer starts on its own.
- R8: `sd_oe` is 1 only while a transmission is in progress. It is 0 during receptions and while idle.
- R9: `buf_wr` loads the buffer and sets `buf_full`. `buf_rd` clears `buf_full` only when the buffer holds a received byte. `buf_wr`, `buf_rd` and `ctl_wr` have no effect while a transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Single-cycle tick; master clock edge rate |
| cfg_master | input | 1 | 1 = channel drives the serial clock |
| cfg_idle_hi | input | 1 | Serial clock rest level |
| cfg_tx_rise | input | 1 | Launch transmit bits on rising (1) or falling (0) edges |
| cfg_rx_rise | input | 1 | Capture receive bits on rising (1) or falling (0) edges |
| cfg_next | input | 2 | Action after each byte: 00/11 off, 01 transmit, 10 receive |
| ctl_wr | input | 1 | Write strobe for enable and direction |
| ctl_en | input | 1 | Enable value written by ctl_wr |
| ctl_tx | input | 1 | Direction value written by ctl_wr (1 = transmit) |
| buf_wr | input | 1 | Buffer write strobe |
| buf_wdata | input | DATA_W | Buffer write data |
| buf_rd | input | 1 | Buffer read strobe |
| buf_rdata | output | DATA_W | Buffer contents |
| buf_full | output | 1 | Buffer status flag |
| chan_en | output | 1 | Channel enabled |
| chan_tx | output | 1 | Channel direction (1 = transmit) |
| chan_busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle end-of-byte request |
| sclk_in | input | 1 | Serial clock from the pin |
| sclk_out | output | 1 | Serial clock to the pin |
| sclk_oe | output | 1 | Serial clock output enable |
| sd_in | input | 1 | Serial data from the pin |
| sd_out | output | 1 | Serial data to the pin |
| sd_oe | output | 1 | Serial data output enable |

## Verification
The bench builds the channel with an eight-bit data width, a two-stage synchronizer and the slave path included. With these values both clock sources, all four combinations of rest level and edge, and the synchronizer latency between an external clock edge and the data update can be exercised. A baud tick every six cycles and a slave half-period of eight cycles leave room for the two-cycle data synchronizer on the input side. Directed sequences cover the start gating, writes made during a transfer, and the chained follow-up actions (transmit then receive, receive then echo). Randomly chosen settings and data cover the rest.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

   typedef enum logic [1:0] {
      NEXT_OFF   = 2'b00,
      NEXT_TX    = 2'b01,
      NEXT_RX    = 2'b10,
      NEXT_OFF_B = 2'b11
   } ssc_next_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } ssc_edge_t;

endpackage

// File: rtl/ssc_edge_src.sv
module ssc_edge_src
   import ssc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_SLAVE   = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cfg_master,
   input  logic      cfg_idle_hi,
   input  logic      active,
   input  logic      baud_tick,
   input  logic      sclk_in,
   input  logic      sd_in,
   output logic      sclk_out,
   output ssc_edge_t ev,
   output logic      sd_s
);

   logic                   sclk_q;
   logic [SYNC_STAGES-1:0] sd_sync;
   ssc_edge_t              m_ev;
   ssc_edge_t              s_ev;

   // master clock: one edge per baud tick while a byte is in flight
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sclk_q <= 1'b0;
      else if (!active)    sclk_q <= cfg_idle_hi;
      else if (baud_tick)  sclk_q <= ~sclk_q;
   end

   assign m_ev.rise = cfg_master & active & baud_tick & ~sclk_q;
   assign m_ev.fall = cfg_master & active & baud_tick &  sclk_q;
   assign sclk_out  = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sd_sync <= '0;
      else        sd_sync <= {sd_sync[SYNC_STAGES-2:0], sd_in};
   end
   assign sd_s = sd_sync[SYNC_STAGES-1];

   generate
      if (HAS_SLAVE) begin : g_slave
         logic [SYNC_STAGES-1:0] sc_sync;
         logic                   sc_prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sc_sync <= '0;
               sc_prev <= 1'b0;
            end else begin
               sc_sync <= {sc_sync[SYNC_STAGES-2:0], sclk_in};
               sc_prev <= sc_sync[SYNC_STAGES-1];
            end
         end
         assign s_ev.rise = ~cfg_master & active &  sc_sync[SYNC_STAGES-1] & ~sc_prev;
         assign s_ev.fall = ~cfg_master & active & ~sc_sync[SYNC_STAGES-1] &  sc_prev;
      end else begin : g_master_only
         assign s_ev = '0;
      end
   endgenerate

   assign ev = cfg_master ? m_ev : s_ev;

   assert_master_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && active && !baud_tick) |=> $stable(sclk_q))
      else $error("master clock moved without a baud tick");

endmodule

// File: rtl/ssc_shifter.sv
module ssc_shifter
   import ssc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              is_tx,
   input  logic              idle_hi,
   input  logic              tx_rise,
   input  logic              rx_rise,
   input  ssc_edge_t         ev,
   input  logic              sd_s,
   output logic              active,
   output logic              done,
   output logic [DATA_W-1:0] shreg,
   output logic              sd_out
);

   localparam int             CW   = $clog2(DATA_W + 1);
   localparam logic [CW-1:0]  LAST = CW'(DATA_W);
   localparam logic [CW-1:0]  PEN  = CW'(DATA_W - 1);

   logic [CW-1:0] pulse_cnt;
   logic [CW-1:0] shift_cnt;
   logic          shift_ev, samp_ev, trail_ev, shift_lead, do_shift;

   assign shift_ev   = tx_rise ? ev.rise : ev.fall;
   assign samp_ev    = rx_rise ? ev.rise : ev.fall;
   assign trail_ev   = idle_hi ? ev.rise : ev.fall;
   // launch edge leaving the rest level: MSB is already on the line at start
   assign shift_lead = tx_rise ^ idle_hi;
   assign do_shift   = shift_lead ? (shift_cnt != '0) : (shift_cnt < PEN);

   assign active = busy & (pulse_cnt != LAST);
   assign done   = busy & (pulse_cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         pulse_cnt <= '0;
         shift_cnt <= '0;
      end else if (load) begin
         shreg     <= load_data;
         pulse_cnt <= '0;
         shift_cnt <= '0;
      end else if (active) begin
         if (is_tx && shift_ev) begin
            if (do_shift) shreg <= {shreg[DATA_W-2:0], 1'b0};
            shift_cnt <= shift_cnt + 1'b1;
         end
         if (!is_tx && samp_ev) shreg <= {shreg[DATA_W-2:0], sd_s};
         if (trail_ev) pulse_cnt <= pulse_cnt + 1'b1;
      end
   end

   assign sd_out = shreg[DATA_W-1];

   assert_pulse_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_cnt <= LAST)
      else $error("pulse counter ran past the byte length");

   assert_sd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && is_tx && !shift_ev) |=> $stable(sd_out))
      else $error("data line changed off a launch edge");

endmodule

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
   import ssc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              buf_wr,
   input  logic [DATA_W-1:0] buf_wdata,
   input  logic              buf_rd,
   input  logic              ctl_wr,
   input  logic              ctl_en,
   input  logic              ctl_tx,
   input  logic [1:0]        cfg_next,
   input  logic              done,
   input  logic [DATA_W-1:0] rx_byte,
   output logic              start,
   output logic              busy,
   output logic              chan_en,
   output logic              chan_tx,
   output logic              buf_full,
   output logic [DATA_W-1:0] buf_q,
   output logic              irq
);

   logic held_rx;   // buffer contents came from the line
   logic sw_ok;

   assign start = chan_en & ~busy & (chan_tx == buf_full);
   assign sw_ok = ~busy & ~start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         chan_en  <= 1'b0;
         chan_tx  <= 1'b0;
         buf_full <= 1'b0;
         buf_q    <= '0;
         held_rx  <= 1'b0;
         irq      <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (start) busy <= 1'b1;
         if (done) begin
            busy <= 1'b0;
            irq  <= 1'b1;
            if (chan_tx) begin
               buf_full <= 1'b0;
            end else begin
               buf_q    <= rx_byte;
               buf_full <= 1'b1;
               held_rx  <= 1'b1;
            end
            case (ssc_next_e'(cfg_next))
               NEXT_TX: begin chan_en <= 1'b1; chan_tx <= 1'b1; end
               NEXT_RX: begin chan_en <= 1'b1; chan_tx <= 1'b0; end
               default: chan_en <= 1'b0;
            endcase
         end else if (sw_ok) begin
            if (buf_wr) begin
               buf_q    <= buf_wdata;
               buf_full <= 1'b1;
               held_rx  <= 1'b0;
            end else if (buf_rd && held_rx) begin
               buf_full <= 1'b0;
               held_rx  <= 1'b0;
            end
            if (ctl_wr) begin
               chan_en <= ctl_en;
               chan_tx <= ctl_tx;
            end
         end
      end
   end

   assert_start_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(chan_en && (chan_tx == buf_full)))
      else $error("transfer began without enable and buffer condition");

   assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq)
      else $error("interrupt request longer than one cycle");

   assert_rx_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !chan_tx) |=> buf_full)
      else $error("reception finished without marking buffer full");

endmodule

// File: rtl/sync_serial_chan.sv
module sync_serial_chan
   import ssc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_SLAVE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              cfg_master,
   input  logic              cfg_idle_hi,
   input  logic              cfg_tx_rise,
   input  logic              cfg_rx_rise,
   input  logic [1:0]        cfg_next,
   input  logic              ctl_wr,
   input  logic              ctl_en,
   input  logic              ctl_tx,
   input  logic              buf_wr,
   input  logic [DATA_W-1:0] buf_wdata,
   input  logic              buf_rd,
   output logic [DATA_W-1:0] buf_rdata,
   output logic              buf_full,
   output logic              chan_en,
   output logic              chan_tx,
   output logic              chan_busy,
   output logic              irq,
   input  logic              sclk_in,
   output logic              sclk_out,
   output logic              sclk_oe,
   input  logic              sd_in,
   output logic              sd_out,
   output logic              sd_oe
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              start, busy, active, done, sd_s;
   logic [DATA_W-1:0] shreg;
   ssc_edge_t         ev;

   ssc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .buf_wr    (buf_wr),
      .buf_wdata (buf_wdata),
      .buf_rd    (buf_rd),
      .ctl_wr    (ctl_wr),
      .ctl_en    (ctl_en),
      .ctl_tx    (ctl_tx),
      .cfg_next  (cfg_next),
      .done      (done),
      .rx_byte   (shreg),
      .start     (start),
      .busy      (busy),
      .chan_en   (chan_en),
      .chan_tx   (chan_tx),
      .buf_full  (buf_full),
      .buf_q     (buf_rdata),
      .irq       (irq)
   );

   ssc_edge_src #(.SYNC_STAGES(SYNC_STAGES), .HAS_SLAVE(HAS_SLAVE)) u_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_master  (cfg_master),
      .cfg_idle_hi (cfg_idle_hi),
      .active      (active),
      .baud_tick   (baud_tick),
      .sclk_in     (sclk_in),
      .sd_in       (sd_in),
      .sclk_out    (sclk_out),
      .ev          (ev),
      .sd_s        (sd_s)
   );

   ssc_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .load      (start),
      .load_data (buf_rdata),
      .is_tx     (chan_tx),
      .idle_hi   (cfg_idle_hi),
      .tx_rise   (cfg_tx_rise),
      .rx_rise   (cfg_rx_rise),
      .ev        (ev),
      .sd_s      (sd_s),
      .active    (active),
      .done      (done),
      .shreg     (shreg),
      .sd_out    (sd_out)
   );

   assign chan_busy = busy;
   assign sclk_oe   = cfg_master;
   assign sd_oe     = busy & chan_tx;

endmodule

// File: tb/sync_serial_chan_tb.sv
module sync_serial_chan_tb;

   localparam int TICK_DIV = 6;
   localparam int HALF     = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n, baud_tick;
   logic       cfg_master, cfg_idle_hi, cfg_tx_rise, cfg_rx_rise;
   logic [1:0] cfg_next;
   logic       ctl_wr, ctl_en, ctl_tx, buf_wr, buf_rd;
   logic [7:0] buf_wdata, buf_rdata;
   logic       buf_full, chan_en, chan_tx, chan_busy, irq;
   logic       sclk_in, sclk_out, sclk_oe, sd_in, sd_out, sd_oe;

   int checks = 0;
   int fails  = 0;

   sync_serial_chan #(.DATA_W(8), .SYNC_STAGES(2), .HAS_SLAVE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cfg_master(cfg_master), .cfg_idle_hi(cfg_idle_hi),
      .cfg_tx_rise(cfg_tx_rise), .cfg_rx_rise(cfg_rx_rise), .cfg_next(cfg_next),
      .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_tx(ctl_tx),
      .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd),
      .buf_rdata(buf_rdata), .buf_full(buf_full), .chan_en(chan_en),
      .chan_tx(chan_tx), .chan_busy(chan_busy), .irq(irq),
      .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
      .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_en(input logic [1:0] nx);
      return (nx == 2'b01) || (nx == 2'b10);
   endfunction

   function automatic bit exp_tx(input logic [1:0] nx);
      return nx == 2'b01;
   endfunction

   initial begin
      baud_tick = 1'b0;
      forever begin
         repeat (TICK_DIV - 1) @(negedge clk);
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   task automatic cfgset(input bit m, input bit idle, input bit txr, input bit rxr,
                         input logic [1:0] nx);
      @(negedge clk);
      cfg_master = m; cfg_idle_hi = idle; cfg_tx_rise = txr; cfg_rx_rise = rxr;
      cfg_next = nx; sclk_in = idle;
      repeat (6) @(negedge clk);
   endtask

   task automatic wr_buf(input logic [7:0] d);
      @(negedge clk); buf_wr = 1'b1; buf_wdata = d;
      @(negedge clk); buf_wr = 1'b0;
   endtask

   task automatic rd_buf();
      @(negedge clk); buf_rd = 1'b1;
      @(negedge clk); buf_rd = 1'b0;
   endtask

   task automatic ctl(input bit en, input bit tx);
      @(negedge clk); ctl_wr = 1'b1; ctl_en = en; ctl_tx = tx;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   // runs one byte as the far end; checks at the cycle irq is seen
   task automatic xfer(input bit is_tx, input logic [7:0] d, input bit poke, input bit pre_sd);
      int pulses = 0, ncap = 0, idx = 0, hcnt = 0, tog = 0, iter = 0;
      bit seen = 0, oe_bad = 0, got = 0;
      logic [7:0] cap = '0;
      logic prev, obs;
      sd_in = is_tx ? pre_sd : d[7];
      prev  = cfg_master ? sclk_out : sclk_in;
      while (!got && iter < 1000) begin
         @(negedge clk);
         iter++;
         buf_wr = 1'b0; ctl_wr = 1'b0;
         if (poke && iter == 20) begin
            buf_wr = 1'b1; buf_wdata = ~d; ctl_wr = 1'b1; ctl_en = 1'b0; ctl_tx = 1'b0;
         end
         if (!cfg_master) begin
            hcnt++;
            if (hcnt >= HALF && tog < 16) begin
               sclk_in = ~sclk_in; tog++; hcnt = 0;
            end
         end
         if (!is_tx && sd_oe && !irq) oe_bad = 1;
         obs = cfg_master ? sclk_out : sclk_in;
         if (obs !== prev) begin
            if (obs == cfg_idle_hi) pulses++;
            if (is_tx) begin
               if (obs != cfg_tx_rise) begin
                  cap = {cap[6:0], sd_out}; ncap++;
                  if (!sd_oe) oe_bad = 1;
               end
            end else begin
               if (obs == cfg_rx_rise) seen = 1;
               else if (seen && idx < 7) begin idx++; sd_in = d[7-idx]; end
            end
            prev = obs;
         end
         if (irq) got = 1;
      end
      buf_wr = 1'b0; ctl_wr = 1'b0;
      chk(got, "R2 completion", got, 1);
      chk(pulses == 8, "R2 pulse count", pulses, 8);
      chk(oe_bad == 0, "R8 data output enable", oe_bad, 0);
      if (cfg_master) chk(sclk_out == cfg_idle_hi, "R4 clock back at rest", sclk_out, cfg_idle_hi);
      if (is_tx) begin
         chk(cap == d && ncap == 8, "R3 transmitted byte", cap, d);
         chk(!buf_full, "R6 buffer emptied", buf_full, 0);
      end else begin
         chk(buf_full && buf_rdata == d, "R6 received byte", buf_rdata, d);
      end
      chk(chan_en == exp_en(cfg_next) && (!exp_en(cfg_next) || chan_tx == exp_tx(cfg_next)),
          "R7 next action", {chan_en, chan_tx}, {exp_en(cfg_next), exp_tx(cfg_next)});
      if (poke) chk(is_tx ? !buf_full : (buf_rdata == d), "R9 write during transfer ignored",
                    buf_rdata, is_tx ? 8'h0 : d);
   endtask

   initial begin
      logic [7:0] d;
      bit m, idle, txr, rxr, tx;
      void'($urandom(32'd4242));
      rst_n = 1'b0; cfg_master = 1'b1; cfg_idle_hi = 1'b0; cfg_tx_rise = 1'b0;
      cfg_rx_rise = 1'b1; cfg_next = 2'b00; ctl_wr = 0; ctl_en = 0; ctl_tx = 0;
      buf_wr = 0; buf_rd = 0; buf_wdata = '0; sclk_in = 1'b0; sd_in = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!buf_full, "R9 reset buffer empty", buf_full, 0);
      chk(!chan_en && !chan_busy, "R7 reset channel off", {chan_en, chan_busy}, 0);
      chk(!irq && !sd_oe, "R8 reset outputs quiet", {irq, sd_oe}, 0);
      chk(sclk_out == 1'b0, "R4 reset clock at rest", sclk_out, 0);

      // R1: transmit enabled with empty buffer must wait
      cfgset(1, 0, 0, 1, 2'b00);
      chk(sclk_oe, "R5 master drives clock", sclk_oe, 1);
      ctl(1, 1);
      repeat (40) @(negedge clk);
      chk(!chan_busy && sclk_out == 1'b0, "R1 no transmit on empty buffer", chan_busy, 0);
      wr_buf(8'hA5);
      xfer(1, 8'hA5, 0, 0);

      // R1: receive enabled with full buffer must wait; R9 read of written data keeps it
      wr_buf(8'h3C);
      ctl(1, 0);
      repeat (40) @(negedge clk);
      chk(!chan_busy, "R1 no receive on full buffer", chan_busy, 0);
      rd_buf();
      chk(buf_full, "R9 read of written byte keeps flag", buf_full, 1);
      // R7: transmit followed by automatic receive
      cfg_next = 2'b10;
      ctl(1, 1);
      xfer(1, 8'h3C, 0, 1'b0);
      xfer(0, 8'h5A, 0, 0);
      repeat (40) @(negedge clk);
      chk(!chan_busy && chan_en && !chan_tx, "R7 rearmed receive waits for read", chan_busy, 0);
      cfg_next = 2'b00;
      sd_in = 1'b1;
      rd_buf();
      xfer(0, 8'hC3, 0, 0);
      rd_buf();
      chk(!buf_full, "R9 read of received byte clears flag", buf_full, 0);

      // R7: receive then echo the byte back
      cfg_next = 2'b01;
      sd_in = 1'b1;
      ctl(1, 0);
      xfer(0, 8'h96, 0, 0);
      cfg_next = 2'b00;
      xfer(1, 8'h96, 0, 0);

      // R9: writes during a transfer, rest high, launch rising
      cfgset(1, 1, 1, 0, 2'b00);
      wr_buf(8'hE1);
      ctl(1, 1);
      xfer(1, 8'hE1, 1, 0);

      // R5: slave mode both directions
      cfgset(0, 0, 0, 1, 2'b00);
      chk(!sclk_oe, "R5 slave releases clock", sclk_oe, 0);
      wr_buf(8'h4B);
      ctl(1, 1);
      xfer(1, 8'h4B, 0, 0);
      sd_in = 1'b1;
      ctl(1, 0);
      xfer(0, 8'hD2, 0, 0);
      rd_buf();
      cfgset(0, 1, 1, 0, 2'b00);
      sd_in = 1'b0;
      ctl(1, 0);
      xfer(0, 8'h69, 1, 0);
      rd_buf();

      // random settings and data
      for (int i = 0; i < 24; i++) begin
         m = $urandom % 2; idle = $urandom % 2; txr = $urandom % 2; rxr = $urandom % 2;
         tx = $urandom % 2; d = 8'($urandom);
         cfgset(m, idle, txr, rxr, 2'b00);
         if (tx) begin
            wr_buf(d); ctl(1, 1); xfer(1, d, 0, 0);
         end else begin
            sd_in = d[7]; ctl(1, 0); xfer(0, d, 0, 0); rd_buf();
         end
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule